// File: doc/BRIEF.md
# Front-End Event Block Integrity Checker

This block sits behind the deserializer of one calorimeter front-end readout channel. It takes a stream of 16-bit words, each with a parity bit on a 17th line. It walks every event block through its fixed structure: a bunch-crossing word, an event-number word, a header word with length, mode and source fields, then strip records, crystal records with their ADC samples, and a closing trailer. Each block is checked against the configured source ID, against the structural length, against word parity and link health, and against the event and bunch-crossing numbers of the trigger it answers.

Triggers enter a small first-in first-out queue. The oldest pending trigger is taken when a block's first word arrives. If no block arrives within a programmable number of idle cycles after a trigger, a timeout status is reported. A status word appears for every block one cycle after its trailer. A per-error saturating counter bank can be read and cleared through a select/clear port. Clearing the channel enable silences the channel completely.

The parser state machine has the states IDLE, EVT (expect event word), HDR (expect length/source word), STRIP (expect strip ID), XTAL (expect crystal ID), SAMP (expect ADC sample), TRAIL (expect trailer) and REPORT (status cycle). Its transitions are as follows:
- A word in IDLE or REPORT goes to EVT.
- EVT goes to HDR, HDR goes to STRIP, STRIP goes to XTAL, and XTAL goes to SAMP.
- SAMP stays in SAMP until the last sample of a crystal arrives. It then goes to XTAL, or to STRIP after the last crystal, or to TRAIL after the last strip.
- TRAIL goes to REPORT.
- REPORT with no word goes to IDLE.
- Timeout expiry from any state goes to REPORT.
- A cleared enable forces IDLE.

Top module: `fe_block_checker`

## Requirements
- R1: A block is 3 header words, then N_STRIP strip records of (1 strip ID word + N_XTAL × (1 crystal ID word + N_SAMP samples)), then 1 trailer word: 284 words by default. `stat_valid` is high for exactly the cycle after the trailer word is accepted, and never while a block's later words are being accepted.
- R2: A block with every field correct reports `stat_flags` = 0.
- R3: Bit 5 of `stat_flags` is set when bits [11:0] of the first word differ from the bunch-crossing number at the head of the trigger queue. Bits [15:12] of that word are ignored.
- R4: Bit 4 of `stat_flags` is set when the second word differs from the event number of the trigger taken for the block.
- R5: Bit 1 of `stat_flags` is set when bits [5:0] of the third word differ from `cfg_src_id`. Bit 6 of that word (mode) has no effect on any flag.
- R6: Bit 2 of `stat_flags` is set when bits [15:7] of the third word differ from the structural block length.
- R7: Each word together with `in_par` must have even parity. Any mismatch in a block sets bit 3 of `stat_flags`.
- R8: A word accepted while `link_ok` is low sets bit 0 of `stat_flags`.
- R9: A trigger pending in IDLE with no word for `cfg_timeout`+1 cycles consumes that trigger and reports `stat_flags` = 0x40. A gap of `cfg_timeout`+1 cycles inside a block reports bit 6 together with the flags gathered so far. In both cases `stat_valid` rises `cfg_timeout`+1 clock edges after the last trigger push or accepted word.
- R10: A block that starts with no pending trigger reports bits 4 and 5 set.
- R11: Triggers are taken in push order. A push into a full queue of Q_DEPTH entries is dropped.
- R12: With `cfg_enable` low, no status is reported, pending triggers are discarded and the statistics counters do not change.
- R13: Counter k (selected by `cnt_sel` = k) counts reported statuses that have bit k set. It saturates at its maximum value and is zeroed by `cnt_clr` with `cnt_sel` = k.
- R14: The first word of the next block may be accepted in the status cycle of the previous block, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Channel enable |
| cfg_src_id | input | 6 | Expected source ID |
| cfg_timeout | input | TMO_W | Idle cycles allowed before a timeout |
| trig_valid | input | 1 | Push a trigger into the queue |
| trig_evt | input | 16 | Trigger event number |
| trig_bx | input | BX_W | Trigger bunch-crossing number |
| in_valid | input | 1 | Input word valid |
| in_data | input | 16 | Input word |
| in_par | input | 1 | Parity bit of the input word |
| link_ok | input | 1 | Link status from the receiver |
| stat_valid | output | 1 | Block status valid (one cycle) |
| stat_flags | output | 7 | Error flags: 0 link, 1 source, 2 length, 3 parity, 4 event, 5 bunch crossing, 6 timeout |
| cnt_sel | input | 3 | Statistics counter select |
| cnt_clr | input | 1 | Clear the selected counter |
| cnt_data | output | CNT_W | Value of the selected counter |

## Verification
A parser index that slips by one word moves the trailer. The status then appears a cycle early or late relative to the 284th word, and the bench catches this on the first block. A wrong comparison field or a stale expected trigger shows as a wrong flag in the status of the very block that exposes it. A miscounted queue shows up a few blocks later as an event mismatch or a missing-trigger flag. Timeout counter errors show as a status edge that lands away from `cfg_timeout`+1 cycles.

// File: rtl/fe_chk_pkg.sv
package fe_chk_pkg;
    localparam int DW       = 16;
    localparam int SRC_W    = 6;
    localparam int LEN_W    = 9;
    localparam int LEN_LSB  = 7;
    localparam int NUM_ERR  = 7;

    localparam int E_LINK = 0;
    localparam int E_SRC  = 1;
    localparam int E_LEN  = 2;
    localparam int E_PAR  = 3;
    localparam int E_EVT  = 4;
    localparam int E_BX   = 5;
    localparam int E_TMO  = 6;

    typedef enum logic [2:0] {
        S_IDLE, S_EVT, S_HDR, S_STRIP, S_XTAL, S_SAMP, S_TRAIL, S_REPORT
    } blk_state_e;

    typedef logic [NUM_ERR-1:0] err_vec_t;
endpackage

// File: rtl/fe_trig_queue.sv
module fe_trig_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         nonempty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          full, do_push, do_pop;

    assign full     = (cnt_q == CW'(DEPTH));
    assign nonempty = (cnt_q != '0);
    assign do_push  = push && !full && !flush;
    assign do_pop   = pop && nonempty && !flush;
    assign head     = mem[rd_q];

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= ptr_inc(wr_q);
            if (do_pop)  rd_q <= ptr_inc(rd_q);
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= push_data;
    end

    // R11: occupancy never exceeds the queue depth
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    // R11: the parser only takes a trigger that is present
    a_r11_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> nonempty);
endmodule

// File: rtl/fe_err_stats.sv
module fe_err_stats
    import fe_chk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stat_valid,
    input  err_vec_t         stat_flags,
    input  logic [2:0]       cnt_sel,
    input  logic             cnt_clr,
    output logic [CNT_W-1:0] cnt_data
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q [NUM_ERR];

    for (genvar g = 0; g < NUM_ERR; g++) begin : g_cnt
        logic sel_clr;
        assign sel_clr = cnt_clr && (cnt_sel == 3'(g));

        always_ff @(posedge clk) begin
            if (!rst_n || sel_clr)
                cnt_q[g] <= '0;
            else if (stat_valid && stat_flags[g] && cnt_q[g] != CNT_MAX)
                cnt_q[g] <= cnt_q[g] + 1'b1;
        end

        // R13: a saturated counter stays at its maximum until cleared
        a_r13_saturate: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[g] == CNT_MAX && !sel_clr) |=> cnt_q[g] == CNT_MAX);
        // R13: a clear of the selected counter zeroes it
        a_r13_clear: assert property (@(posedge clk) disable iff (!rst_n)
            sel_clr |=> cnt_q[g] == '0);
    end

    always_comb begin
        cnt_data = '0;
        for (int i = 0; i < NUM_ERR; i++)
            if (cnt_sel == 3'(i)) cnt_data = cnt_q[i];
    end
endmodule

// File: rtl/fe_block_parser.sv
module fe_block_parser
    import fe_chk_pkg::*;
#(
    parameter int N_STRIP = 5,
    parameter int N_XTAL  = 5,
    parameter int N_SAMP  = 10,
    parameter int EVT_W   = 16,
    parameter int BX_W    = 12,
    parameter int TMO_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic [SRC_W-1:0] cfg_src_id,
    input  logic [TMO_W-1:0] cfg_timeout,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_data,
    input  logic             in_par,
    input  logic             link_ok,
    input  logic             q_nonempty,
    input  logic [EVT_W-1:0] q_evt,
    input  logic [BX_W-1:0]  q_bx,
    output logic             q_pop,
    output logic             stat_valid,
    output err_vec_t         stat_flags
);
    localparam int BLK_LEN = 3 + N_STRIP * (1 + N_XTAL * (1 + N_SAMP)) + 1;
    localparam int STW = (N_STRIP > 1) ? $clog2(N_STRIP) : 1;
    localparam int XTW = (N_XTAL  > 1) ? $clog2(N_XTAL)  : 1;
    localparam int SMW = (N_SAMP  > 1) ? $clog2(N_SAMP)  : 1;

    blk_state_e       state_q, state_d;
    err_vec_t         flags_q, flags_d;
    logic [STW-1:0]   strip_q;
    logic [XTW-1:0]   xtal_q;
    logic [SMW-1:0]   samp_q;
    logic [EVT_W-1:0] exp_evt_q;
    logic             exp_none_q;
    logic [TMO_W-1:0] tmo_q;
    logic             idle_like, in_block, acc, par_bad;
    logic             tmo_active, tmo_fire;
    logic             last_samp, last_xtal, last_strip;

    assign idle_like  = (state_q == S_IDLE) || (state_q == S_REPORT);
    assign in_block   = !idle_like;
    assign acc        = in_valid && cfg_enable;
    assign par_bad    = ^{in_par, in_data};
    assign last_samp  = (samp_q  == SMW'(N_SAMP - 1));
    assign last_xtal  = (xtal_q  == XTW'(N_XTAL - 1));
    assign last_strip = (strip_q == STW'(N_STRIP - 1));
    assign tmo_active = cfg_enable && !acc && (in_block || (idle_like && q_nonempty));
    assign tmo_fire   = tmo_active && (tmo_q == cfg_timeout);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!cfg_enable) begin
            state_d = S_IDLE;
        end else if (tmo_fire) begin
            state_d = S_REPORT;
        end else if (acc) begin
            unique case (state_q)
                S_IDLE, S_REPORT: state_d = S_EVT;
                S_EVT:            state_d = S_HDR;
                S_HDR:            state_d = S_STRIP;
                S_STRIP:          state_d = S_XTAL;
                S_XTAL:           state_d = S_SAMP;
                S_SAMP: begin
                    if (last_samp) begin
                        if (!last_xtal)       state_d = S_XTAL;
                        else if (!last_strip) state_d = S_STRIP;
                        else                  state_d = S_TRAIL;
                    end
                end
                S_TRAIL:          state_d = S_REPORT;
                default:          state_d = S_IDLE;
            endcase
        end else if (state_q == S_REPORT) begin
            state_d = S_IDLE;
        end
    end

    // Flag accumulation
    always_comb begin
        flags_d = flags_q;
        if (acc && idle_like) begin
            flags_d = '0;
            if (!q_nonempty) begin
                flags_d[E_EVT] = 1'b1;
                flags_d[E_BX]  = 1'b1;
            end else if (in_data[BX_W-1:0] != q_bx) begin
                flags_d[E_BX] = 1'b1;
            end
        end
        if (acc && !link_ok) flags_d[E_LINK] = 1'b1;
        if (acc && par_bad)  flags_d[E_PAR]  = 1'b1;
        if (acc && state_q == S_EVT && !exp_none_q && in_data[EVT_W-1:0] != exp_evt_q)
            flags_d[E_EVT] = 1'b1;
        if (acc && state_q == S_HDR) begin
            if (in_data[SRC_W-1:0] != cfg_src_id)
                flags_d[E_SRC] = 1'b1;
            if (in_data[LEN_LSB +: LEN_W] != LEN_W'(BLK_LEN))
                flags_d[E_LEN] = 1'b1;
        end
        if (tmo_fire) begin
            if (idle_like) flags_d = '0;
            flags_d[E_TMO] = 1'b1;
        end
        if (!cfg_enable) flags_d = '0;
    end

    // Datapath registers: flags, expected trigger, structure indices, timeout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q    <= '0;
            exp_evt_q  <= '0;
            exp_none_q <= 1'b0;
            strip_q    <= '0;
            xtal_q     <= '0;
            samp_q     <= '0;
            tmo_q      <= '0;
        end else begin
            flags_q <= flags_d;
            if (acc && idle_like) begin
                exp_evt_q  <= q_evt;
                exp_none_q <= !q_nonempty;
            end
            if (acc) begin
                unique case (state_q)
                    S_HDR:   strip_q <= '0;
                    S_STRIP: xtal_q  <= '0;
                    S_XTAL:  samp_q  <= '0;
                    S_SAMP: begin
                        if (!last_samp)      samp_q  <= samp_q + 1'b1;
                        else if (!last_xtal) xtal_q  <= xtal_q + 1'b1;
                        else                 strip_q <= strip_q + 1'b1;
                    end
                    default: ;
                endcase
            end
            if (!tmo_active || tmo_fire) tmo_q <= '0;
            else                         tmo_q <= tmo_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        stat_valid = (state_q == S_REPORT);
        stat_flags = stat_valid ? flags_q : '0;
        q_pop      = (acc && idle_like && q_nonempty) || (tmo_fire && idle_like);
    end

    // R1: the trailer is followed at once by a status cycle
    a_r1_status_after_trailer: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TRAIL && acc) |=> stat_valid);
    // R9: a timeout is reported in the following cycle with its flag
    a_r9_timeout_reported: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_fire |=> (stat_valid && stat_flags[E_TMO]));
    // R12: a disabled channel never reports
    a_r12_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !stat_valid);
    // R8: a word taken on a failed link is flagged at the block status
    a_r8_link_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_block && !link_ok) |=> flags_q[E_LINK]);
endmodule

// File: rtl/fe_block_checker.sv
module fe_block_checker
    import fe_chk_pkg::*;
#(
    parameter int N_STRIP = 5,
    parameter int N_XTAL  = 5,
    parameter int N_SAMP  = 10,
    parameter int BX_W    = 12,
    parameter int Q_DEPTH = 4,
    parameter int TMO_W   = 16,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_enable,
    input  logic [5:0]         cfg_src_id,
    input  logic [TMO_W-1:0]   cfg_timeout,
    input  logic               trig_valid,
    input  logic [15:0]        trig_evt,
    input  logic [BX_W-1:0]    trig_bx,
    input  logic               in_valid,
    input  logic [15:0]        in_data,
    input  logic               in_par,
    input  logic               link_ok,
    output logic               stat_valid,
    output logic [6:0]         stat_flags,
    input  logic [2:0]         cnt_sel,
    input  logic               cnt_clr,
    output logic [CNT_W-1:0]   cnt_data
);
    localparam int EVT_W = 16;
    localparam int QW    = EVT_W + BX_W;

    logic [QW-1:0] q_head;
    logic          q_nonempty, q_pop;
    err_vec_t      flags;

    fe_trig_queue #(.DEPTH(Q_DEPTH), .W(QW)) i_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!cfg_enable),
        .push      (trig_valid),
        .push_data ({trig_evt, trig_bx}),
        .pop       (q_pop),
        .head      (q_head),
        .nonempty  (q_nonempty)
    );

    fe_block_parser #(
        .N_STRIP (N_STRIP),
        .N_XTAL  (N_XTAL),
        .N_SAMP  (N_SAMP),
        .EVT_W   (EVT_W),
        .BX_W    (BX_W),
        .TMO_W   (TMO_W)
    ) i_parser (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_enable  (cfg_enable),
        .cfg_src_id  (cfg_src_id),
        .cfg_timeout (cfg_timeout),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_par      (in_par),
        .link_ok     (link_ok),
        .q_nonempty  (q_nonempty),
        .q_evt       (q_head[QW-1:BX_W]),
        .q_bx        (q_head[BX_W-1:0]),
        .q_pop       (q_pop),
        .stat_valid  (stat_valid),
        .stat_flags  (flags)
    );

    assign stat_flags = flags;

    fe_err_stats #(.CNT_W(CNT_W)) i_stats (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_valid (stat_valid),
        .stat_flags (flags),
        .cnt_sel    (cnt_sel),
        .cnt_clr    (cnt_clr),
        .cnt_data   (cnt_data)
    );
endmodule

// File: tb/test_fe_block_checker.sv
module test_fe_block_checker;
    localparam int CW      = 4;
    localparam int BLK     = 284;
    localparam logic [5:0] SRC = 6'h2B;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_enable = 1'b1;
    logic [15:0] cfg_timeout = 16'd50;
    logic trig_valid = 1'b0;
    logic [15:0] trig_evt = '0;
    logic [11:0] trig_bx = '0;
    logic in_valid = 1'b0, in_par = 1'b0, link_ok = 1'b1;
    logic [15:0] in_data = '0;
    logic stat_valid;
    logic [6:0] stat_flags;
    logic [2:0] cnt_sel = '0;
    logic cnt_clr = 1'b0;
    logic [CW-1:0] cnt_data;

    always #2 clk = ~clk;

    fe_block_checker #(.CNT_W(CW)) i_fe_block_checker (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_src_id(SRC),
        .cfg_timeout(cfg_timeout), .trig_valid(trig_valid), .trig_evt(trig_evt),
        .trig_bx(trig_bx), .in_valid(in_valid), .in_data(in_data), .in_par(in_par),
        .link_ok(link_ok), .stat_valid(stat_valid), .stat_flags(stat_flags),
        .cnt_sel(cnt_sel), .cnt_clr(cnt_clr), .cnt_data(cnt_data)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic first_stat, last_stat;
    logic [6:0] first_flags, last_flags;
    int early = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    typedef struct packed {
        bit bad_bx, bad_evt, bad_src, bad_len, bad_par, link_drop, no_trig, mode;
        logic [6:0] exp_flags;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{0,0,0,0,0,0,0,0, 7'h00},
        '{0,0,0,0,0,0,0,1, 7'h00},
        '{1,0,0,0,0,0,0,0, 7'h20},
        '{0,1,0,0,0,0,0,0, 7'h10},
        '{0,0,1,0,0,0,0,0, 7'h02},
        '{0,0,0,1,0,0,0,0, 7'h04},
        '{0,0,0,0,1,0,0,0, 7'h08},
        '{0,0,0,0,0,1,0,0, 7'h01},
        '{0,0,0,0,0,0,1,0, 7'h30},
        '{1,0,0,0,1,1,0,0, 7'h29}
    };

    task automatic push_trig(input logic [15:0] e, input logic [11:0] b);
        @(negedge clk);
        trig_valid = 1'b1; trig_evt = e; trig_bx = b;
        @(negedge clk);
        trig_valid = 1'b0;
    endtask

    function automatic logic [15:0] hdr(input bit bad_len, input bit mode, input bit bad_src);
        return {bad_len ? 9'd283 : 9'd284, mode, bad_src ? (SRC ^ 6'h01) : SRC};
    endfunction

    task automatic blk(input int nwords, input logic [15:0] bxw, input logic [15:0] evw,
                       input logic [15:0] hdw, input int par_at, input int link_at);
        for (int i = 0; i < nwords; i++) begin
            logic [15:0] w;
            @(negedge clk);
            if (i == 0) begin
                first_stat = stat_valid; first_flags = stat_flags;
            end else if (stat_valid) early++;
            w = (i == 0) ? bxw : (i == 1) ? evw : (i == 2) ? hdw : 16'(i * 97 + 16'h55);
            in_valid = 1'b1; in_data = w;
            in_par = (^w) ^ (i == par_at);
            link_ok = (i != link_at);
        end
    endtask

    task automatic finish_blk();
        @(negedge clk);
        in_valid = 1'b0; link_ok = 1'b1;
        last_stat = stat_valid; last_flags = stat_flags;
    endtask

    task automatic wait_stat(output int n);
        n = 0;
        while (n < 2000) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (stat_valid) break;
        end
    endtask

    task automatic rd(input int sel, output int v);
        @(negedge clk);
        cnt_sel = 3'(sel);
        #1 v = int'(cnt_data);
    endtask

    task automatic clr(input int sel);
        @(negedge clk);
        cnt_sel = 3'(sel); cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v, n, saved;
        int tally [7];
        foreach (tally[k]) tally[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(stat_valid == 1'b0, "reset R1 stat_valid", int'(stat_valid), 0);
        for (int k = 0; k < 7; k++) begin
            rd(k, v);
            chk(v == 0, "reset R13 counter", v, 0);
        end

        // Table walk: R1..R8, R10
        for (int i = 0; i < 10; i++) begin
            vec_t t = VECS[i];
            logic [15:0] e = 16'(100 + i);
            logic [11:0] b = 12'(200 + i);
            if (!t.no_trig) push_trig(e, b);
            early = 0;
            blk(BLK, {4'hA, t.bad_bx ? (b ^ 12'h001) : b},
                t.bad_evt ? (e ^ 16'h0100) : e,
                hdr(t.bad_len, t.mode, t.bad_src),
                t.bad_par ? 150 : -1, t.link_drop ? 100 : -1);
            finish_blk();
            chk(early == 0, "R1 no status before trailer", early, 0);
            chk(last_stat == 1'b1, "R1 status after trailer", int'(last_stat), 1);
            chk(last_flags == t.exp_flags, "R2-R8/R10 vector flags (R2 R3 R4 R5 R6 R7 R8 R10)",
                int'(last_flags), int'(t.exp_flags));
            for (int k = 0; k < 7; k++)
                if (t.exp_flags[k] && tally[k] < 15) tally[k]++;
            @(negedge clk);
            chk(stat_valid == 1'b0, "R1 status lasts one cycle", int'(stat_valid), 0);
        end
        for (int k = 0; k < 7; k++) begin
            rd(k, v);
            chk(v == tally[k], "R13 counter tally", v, tally[k]);
        end

        // R9: idle timeout
        cfg_timeout = 16'd20;
        push_trig(16'd7, 12'd7);
        wait_stat(n);
        chk(n == 21, "R9 idle timeout latency", n, 21);
        chk(stat_flags == 7'h40, "R9 idle timeout flags", int'(stat_flags), 'h40);
        // popped trigger: next block finds none (R9, R10)
        blk(BLK, 16'd7, 16'd7, hdr(0, 0, 0), -1, -1);
        finish_blk();
        chk(last_flags == 7'h30, "R9 timeout consumed trigger", int'(last_flags), 'h30);

        // R9: mid-block gap keeps earlier flags
        push_trig(16'd8, 12'd8);
        blk(20, 16'd8, 16'd8, hdr(0, 0, 1), -1, -1);
        @(negedge clk);
        in_valid = 1'b0;
        wait_stat(n);
        chk(n == 21, "R9 mid-block timeout latency", n, 21);
        chk(stat_flags == 7'h42, "R9 mid-block timeout flags", int'(stat_flags), 'h42);

        // R11 + R14: queue order, overflow drop, back-to-back blocks
        cfg_timeout = 16'd50;
        for (int k = 0; k < 5; k++) push_trig(16'(300 + k), 12'(400 + k));
        early = 0;
        for (int k = 0; k < 5; k++) begin
            blk(BLK, 16'(400 + k), 16'(300 + k), hdr(0, 0, 0), -1, -1);
            if (k > 0) begin
                chk(first_stat == 1'b1, "R14 back-to-back status", int'(first_stat), 1);
                chk(first_flags == 7'h00, "R11 queue order flags", int'(first_flags), 0);
            end
        end
        finish_blk();
        chk(early == 0, "R1 no early status back-to-back", early, 0);
        chk(last_flags == 7'h30, "R11 push into full queue dropped", int'(last_flags), 'h30);

        // R13: saturation and clear
        clr(6);
        cfg_timeout = 16'd2;
        for (int k = 0; k < 17; k++) begin
            push_trig(16'd1, 12'd1);
            wait_stat(n);
        end
        rd(6, v);
        chk(v == 15, "R13 saturation", v, 15);
        clr(6);
        rd(6, v);
        chk(v == 0, "R13 clear", v, 0);

        // R12: disabled channel
        cfg_timeout = 16'd20;
        rd(1, saved);
        @(negedge clk);
        cfg_enable = 1'b0;
        push_trig(16'd9, 12'd9);
        early = 0;
        blk(BLK, 16'd9, 16'd9, hdr(1, 0, 1), 5, 6);
        finish_blk();
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (stat_valid) early++;
        end
        chk(early == 0 && last_stat == 1'b0, "R12 no status while disabled", early, 0);
        rd(1, v);
        chk(v == saved, "R12 counters unchanged", v, saved);
        @(negedge clk);
        cfg_enable = 1'b1;
        blk(BLK, 16'd9, 16'd9, hdr(0, 0, 0), -1, -1);
        finish_blk();
        chk(last_flags == 7'h30, "R12 queue flushed while disabled", int'(last_flags), 'h30);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule